// File: doc/BRIEF.md
# Bitmap-Compressed DFA Lookup Pipeline

This block walks a compressed deterministic finite automaton at one input byte per clock. The automaton's next-state table is not held in full. Each state points to a shared 64-bit bitmap and to a row base in a transition memory. Bit `i` of a bitmap covers the four character codes `4i..4i+3`. A set bit marks a place where the next state changes from the previous block of four codes. The next state for character `c` is found by counting the set bits from bit 0 up to bit `c>>2`. One is subtracted from that count, the result is added to the row base, and the transition memory is read at that address. States with the same bitmap share one bitmap entry. States whose transitions are close enough can point at the same row, so no chain of default transitions ever has to be followed.

A lookup takes four cycles: state entry, then bitmap, then rank plus transition read, then write-back. To keep the pipe full, the block serves four independent flows in a fixed rotation. It announces which flow tag it expects on every cycle. Because of this rotation, a flow's next byte arrives exactly when its previous lookup has written the flow's state register. A separate load port fills the three tables. It only writes while the pipe is empty and no byte is being offered.

Top module: `dfa_lookup_pipe`

## Requirements
- R1: While reset is asserted and directly after its release, every flow's current state is 0, `out_valid_o` and `tag_err_o` are 0, and `next_flow_o` is 0.
- R2: `next_flow_o` advances by one, modulo 4, on every clock after reset.
- R3: For a byte `c` accepted for a flow in state `s`, the reported next state is `trans[(row(s) + popcount(bitmap[bid(s)] bits 0..c[7:2]) - 1) mod 2^ROW_W]`. The rank term is taken modulo 64.
- R4: A byte accepted at clock edge `t` produces `out_valid_o`, carrying the same flow tag, after edge `t+3`. The next byte of that flow, offered four cycles later, starts from the updated state.
- R5: `out_match_o` equals the accept bit of the reported next state.
- R6: A valid byte whose flow tag differs from `next_flow_o` raises `tag_err_o` for one cycle after that edge. It causes no output and no state change.
- R7: `flow_restart_i[f]` sets flow `f` to state 0 at the next edge and leaves the other flows alone. It wins over a lookup of flow `f` that completes on the same edge.
- R8: `load_ready_o` is 1 only when `in_valid_i` is 0 and no lookup is in flight. A load strobe while it is 0 writes nothing.
- R9: The load target is set by `ld_sel_i`. With 0, a state entry is written: row base in `ld_data_i[ROW_W-1:0]`, bitmap id in the next `BMP_ID_W` bits, and the accept bit directly above those. With 1, a 64-bit bitmap is written. With 2, a transition is written in `ld_data_i[STATE_W-1:0]`. With 3, nothing is written.
- R10: A cycle with `in_valid_i` low produces no output four cycles later and changes no flow state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input byte present |
| in_flow_i | input | 2 | Flow tag of the input byte |
| in_byte_i | input | 8 | Input character |
| flow_restart_i | input | 4 | Per-flow return to state 0 |
| next_flow_o | output | 2 | Flow tag expected this cycle |
| tag_err_o | output | 1 | Previous cycle offered a wrongly tagged byte |
| out_valid_o | output | 1 | Lookup result present |
| out_flow_o | output | 2 | Flow of the result |
| out_state_o | output | STATE_W | Next state reached |
| out_match_o | output | 1 | Next state is accepting |
| ld_en_i | input | 1 | Table write strobe |
| ld_sel_i | input | 2 | Table select |
| ld_addr_i | input | max(STATE_W,BMP_ID_W,ROW_W) | Table address |
| ld_data_i | input | max(64,1+BMP_ID_W+ROW_W,STATE_W) | Table write data |
| load_ready_o | output | 1 | Table writes are taken this cycle |

## Verification
The bench builds the block with `STATE_W=4`, `BMP_ID_W=2` and `ROW_W=6`. That gives 16 states, 4 bitmaps and 64 transition words. With so few bitmaps, many states share a bitmap group. Random row bases regularly push `row + rank` past the end of the transition memory, so the wrap-around is exercised. One all-ones bitmap and one single-bit bitmap reach both extremes of the rank, from 0 to 63. Because every table fits in a few dozen words, the random byte traffic reaches each entry many times. It also mixes in wrong tags, restarts (including one that collides with a write-back) and loads attempted mid-stream.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
  localparam int NUM_FLOWS = 4;
  localparam int FLOW_W    = 2;
  localparam int BMP_W     = 64;
  localparam int BLK_W     = 6;

  typedef enum logic [1:0] {
    LD_STATE  = 2'd0,
    LD_BITMAP = 2'd1,
    LD_TRANS  = 2'd2,
    LD_NONE   = 2'd3
  } ld_sel_e;
endpackage

// File: rtl/dfa_table_mem.sv
// Flop-based table: one write port, N_RD combinational read ports.
module dfa_table_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int N_RD   = 1
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [N_RD*ADDR_W-1:0]   rd_addr,
  output logic [N_RD*DATA_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_data[p*DATA_W +: DATA_W] = mem_q[rd_addr[p*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/dfa_rank.sv
// Bitmap rank: counts set bits 0..blk, subtracts one, offsets the row base.
module dfa_rank
  import dfa_pkg::*;
#(
  parameter int ROW_W = 9
) (
  input  logic [BMP_W-1:0] bmp,
  input  logic [BLK_W-1:0] blk,
  input  logic [ROW_W-1:0] base,
  output logic [ROW_W-1:0] addr
);
  localparam int CNT_W = $clog2(BMP_W) + 1;

  logic [BMP_W-1:0] in_range;
  logic [BMP_W-1:0] hit;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] rank;

  for (genvar i = 0; i < BMP_W; i++) begin : g_rng
    assign in_range[i] = (blk >= BLK_W'(i));
  end

  assign hit = bmp & in_range;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < BMP_W; i++) begin
      cnt = cnt + CNT_W'(hit[i]);
    end
  end

  assign rank = BLK_W'(cnt - CNT_W'(1));
  assign addr = base + ROW_W'(rank);
endmodule

// File: rtl/dfa_flow_state.sv
// Per-flow current-state registers with write-back and restart.
module dfa_flow_state
  import dfa_pkg::*;
#(
  parameter int STATE_W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [FLOW_W-1:0]              rd_flow,
  output logic [STATE_W-1:0]             rd_state,
  input  logic                           wr_en,
  input  logic [FLOW_W-1:0]              wr_flow,
  input  logic [STATE_W-1:0]             wr_state,
  input  logic [NUM_FLOWS-1:0]           restart,
  output logic [NUM_FLOWS*STATE_W-1:0]   states
);
  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
    logic [STATE_W-1:0] st_q;
    logic [STATE_W-1:0] st_d;

    always_comb begin
      st_d = st_q;
      if (wr_en && (wr_flow == FLOW_W'(f))) begin
        st_d = wr_state;
      end
      if (restart[f]) begin
        st_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
      end else begin
        st_q <= st_d;
      end
    end

    assign states[f*STATE_W +: STATE_W] = st_q;
  end

  assign rd_state = states[rd_flow*STATE_W +: STATE_W];
endmodule

// File: rtl/dfa_lookup_pipe.sv
module dfa_lookup_pipe
  import dfa_pkg::*;
#(
  parameter int STATE_W  = 6,
  parameter int BMP_ID_W = 4,
  parameter int ROW_W    = 9,
  localparam int ENTRY_W   = BMP_ID_W + ROW_W,
  localparam int LD_ADDR_W = (STATE_W > BMP_ID_W) ? ((STATE_W > ROW_W) ? STATE_W : ROW_W)
                                                  : ((BMP_ID_W > ROW_W) ? BMP_ID_W : ROW_W),
  localparam int LD_DATA_W = ((ENTRY_W + 1) > BMP_W) ? ENTRY_W + 1 : BMP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid_i,
  input  logic [FLOW_W-1:0]     in_flow_i,
  input  logic [7:0]            in_byte_i,
  input  logic [NUM_FLOWS-1:0]  flow_restart_i,
  output logic [FLOW_W-1:0]     next_flow_o,
  output logic                  tag_err_o,
  output logic                  out_valid_o,
  output logic [FLOW_W-1:0]     out_flow_o,
  output logic [STATE_W-1:0]    out_state_o,
  output logic                  out_match_o,
  input  logic                  ld_en_i,
  input  logic [1:0]            ld_sel_i,
  input  logic [LD_ADDR_W-1:0]  ld_addr_i,
  input  logic [LD_DATA_W-1:0]  ld_data_i,
  output logic                  load_ready_o
);
  // ---------------- rotation slot ----------------
  logic [FLOW_W-1:0] slot_q, slot_d;
  logic              take, mismatch;
  logic              err_q, err_d;

  assign slot_d   = slot_q + FLOW_W'(1);
  assign take     = in_valid_i && (in_flow_i == slot_q);
  assign mismatch = in_valid_i && (in_flow_i != slot_q);
  assign err_d    = mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      err_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      err_q  <= err_d;
    end
  end

  // ---------------- pipeline control ----------------
  logic s1_v_q, s2_v_q, s3_v_q, out_v_q;
  logic s1_v_d, s2_v_d, s3_v_d, out_v_d;

  assign s1_v_d  = take;
  assign s2_v_d  = s1_v_q;
  assign s3_v_d  = s2_v_q;
  assign out_v_d = s3_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q  <= 1'b0;
      s2_v_q  <= 1'b0;
      s3_v_q  <= 1'b0;
      out_v_q <= 1'b0;
    end else begin
      s1_v_q  <= s1_v_d;
      s2_v_q  <= s2_v_d;
      s3_v_q  <= s3_v_d;
      out_v_q <= out_v_d;
    end
  end

  // ---------------- table load ----------------
  logic ld_go, we_state, we_bmp, we_trans;

  assign load_ready_o = !in_valid_i && !s1_v_q && !s2_v_q && !s3_v_q;
  assign ld_go        = ld_en_i && load_ready_o;
  assign we_state     = ld_go && (ld_sel_e'(ld_sel_i) == LD_STATE);
  assign we_bmp       = ld_go && (ld_sel_e'(ld_sel_i) == LD_BITMAP);
  assign we_trans     = ld_go && (ld_sel_e'(ld_sel_i) == LD_TRANS);

  // ---------------- flow states ----------------
  logic [STATE_W-1:0]           cur_state;
  logic [NUM_FLOWS*STATE_W-1:0] flow_state_q;
  logic [FLOW_W-1:0]            s3_flow_q;
  logic [STATE_W-1:0]           s3_next_q;

  dfa_flow_state #(.STATE_W(STATE_W)) u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_flow  (in_flow_i),
    .rd_state (cur_state),
    .wr_en    (s3_v_q),
    .wr_flow  (s3_flow_q),
    .wr_state (s3_next_q),
    .restart  (flow_restart_i),
    .states   (flow_state_q)
  );

  // ---------------- stage 1: state entry ----------------
  logic [ENTRY_W-1:0]  entry;
  logic [FLOW_W-1:0]   s1_flow_q;
  logic [BLK_W-1:0]    s1_blk_q;
  logic [BMP_ID_W-1:0] s1_bid_q;
  logic [ROW_W-1:0]    s1_row_q;
  logic                unused_low;

  assign unused_low = ^in_byte_i[1:0];

  dfa_table_mem #(.ADDR_W(STATE_W), .DATA_W(ENTRY_W), .N_RD(1)) u_state_mem (
    .clk     (clk),
    .wr_en   (we_state),
    .wr_addr (ld_addr_i[STATE_W-1:0]),
    .wr_data (ld_data_i[ENTRY_W-1:0]),
    .rd_addr (cur_state),
    .rd_data (entry)
  );

  always_ff @(posedge clk) begin
    if (take) begin
      s1_flow_q <= in_flow_i;
      s1_blk_q  <= in_byte_i[7:2];
      s1_bid_q  <= entry[ROW_W +: BMP_ID_W];
      s1_row_q  <= entry[ROW_W-1:0];
    end
  end

  // ---------------- stage 2: bitmap ----------------
  logic [BMP_W-1:0]  bmp_rd;
  logic [FLOW_W-1:0] s2_flow_q;
  logic [BLK_W-1:0]  s2_blk_q;
  logic [ROW_W-1:0]  s2_row_q;
  logic [BMP_W-1:0]  s2_bmp_q;

  dfa_table_mem #(.ADDR_W(BMP_ID_W), .DATA_W(BMP_W), .N_RD(1)) u_bmp_mem (
    .clk     (clk),
    .wr_en   (we_bmp),
    .wr_addr (ld_addr_i[BMP_ID_W-1:0]),
    .wr_data (ld_data_i[BMP_W-1:0]),
    .rd_addr (s1_bid_q),
    .rd_data (bmp_rd)
  );

  always_ff @(posedge clk) begin
    if (s1_v_q) begin
      s2_flow_q <= s1_flow_q;
      s2_blk_q  <= s1_blk_q;
      s2_row_q  <= s1_row_q;
      s2_bmp_q  <= bmp_rd;
    end
  end

  // ---------------- stage 3: rank and transition ----------------
  logic [ROW_W-1:0]   trans_addr;
  logic [STATE_W-1:0] trans_rd;

  dfa_rank #(.ROW_W(ROW_W)) u_rank (
    .bmp  (s2_bmp_q),
    .blk  (s2_blk_q),
    .base (s2_row_q),
    .addr (trans_addr)
  );

  dfa_table_mem #(.ADDR_W(ROW_W), .DATA_W(STATE_W), .N_RD(1)) u_trans_mem (
    .clk     (clk),
    .wr_en   (we_trans),
    .wr_addr (ld_addr_i[ROW_W-1:0]),
    .wr_data (ld_data_i[STATE_W-1:0]),
    .rd_addr (trans_addr),
    .rd_data (trans_rd)
  );

  always_ff @(posedge clk) begin
    if (s2_v_q) begin
      s3_flow_q <= s2_flow_q;
      s3_next_q <= trans_rd;
    end
  end

  // ---------------- stage 4: write-back and result ----------------
  logic              acc_rd;
  logic [FLOW_W-1:0] out_flow_q;
  logic [STATE_W-1:0] out_state_q;
  logic              out_match_q;

  dfa_table_mem #(.ADDR_W(STATE_W), .DATA_W(1), .N_RD(1)) u_acc_mem (
    .clk     (clk),
    .wr_en   (we_state),
    .wr_addr (ld_addr_i[STATE_W-1:0]),
    .wr_data (ld_data_i[ENTRY_W]),
    .rd_addr (s3_next_q),
    .rd_data (acc_rd)
  );

  always_ff @(posedge clk) begin
    if (s3_v_q) begin
      out_flow_q  <= s3_flow_q;
      out_state_q <= s3_next_q;
      out_match_q <= acc_rd;
    end
  end

  assign next_flow_o = slot_q;
  assign tag_err_o   = err_q;
  assign out_valid_o = out_v_q;
  assign out_flow_o  = out_flow_q;
  assign out_state_o = out_state_q;
  assign out_match_o = out_match_q;
endmodule

// File: rtl/dfa_lookup_pipe_chk.sv
module dfa_lookup_pipe_chk
  import dfa_pkg::*;
#(
  parameter int STATE_W = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid_i,
  input logic [FLOW_W-1:0]            in_flow_i,
  input logic [NUM_FLOWS-1:0]         flow_restart_i,
  input logic [FLOW_W-1:0]            next_flow_o,
  input logic                         tag_err_o,
  input logic                         out_valid_o,
  input logic [FLOW_W-1:0]            out_flow_o,
  input logic                         load_ready_o,
  input logic [NUM_FLOWS*STATE_W-1:0] flow_state_q
);
  logic [2:0] age_q;
  logic       acc_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 3'd4) begin
      age_q <= age_q + 3'd1;
    end
  end

  assign acc_in = in_valid_i && (in_flow_i == next_flow_o);

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 3'd0) |-> (next_flow_o == FLOW_W'($past(next_flow_o) + FLOW_W'(1)))); // R2

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4) |-> (out_valid_o == $past(acc_in, 4))); // R4

  AST_OUT_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q == 3'd4) && out_valid_o) |-> (out_flow_o == $past(in_flow_i, 4))); // R4

  AST_TAG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 3'd0) |-> (tag_err_o == $past(in_valid_i && (in_flow_i != next_flow_o)))); // R6

  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_in |=> !load_ready_o); // R8

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_rst
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      flow_restart_i[f] |=> (flow_state_q[f*STATE_W +: STATE_W] == '0)); // R7
  end
endmodule

bind dfa_lookup_pipe dfa_lookup_pipe_chk #(.STATE_W(STATE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid_i     (in_valid_i),
  .in_flow_i      (in_flow_i),
  .flow_restart_i (flow_restart_i),
  .next_flow_o    (next_flow_o),
  .tag_err_o      (tag_err_o),
  .out_valid_o    (out_valid_o),
  .out_flow_o     (out_flow_o),
  .load_ready_o   (load_ready_o),
  .flow_state_q   (flow_state_q)
);

// File: tb/dfa_lookup_pipe_tb.sv
module dfa_lookup_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;
  localparam int BW = 2;
  localparam int RW = 6;
  localparam int NS = 1 << SW;
  localparam int NB = 1 << BW;
  localparam int NT = 1 << RW;
  localparam int AW = 6;
  localparam int DW = 64;

  logic          clk, rst_n;
  logic          in_valid;
  logic [1:0]    in_flow;
  logic [7:0]    in_byte;
  logic [3:0]    flow_restart;
  logic [1:0]    next_flow;
  logic          tag_err, out_valid, out_match, load_ready;
  logic [1:0]    out_flow;
  logic [SW-1:0] out_state;
  logic          ld_en;
  logic [1:0]    ld_sel;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;

  dfa_lookup_pipe #(.STATE_W(SW), .BMP_ID_W(BW), .ROW_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_flow_i(in_flow),
    .in_byte_i(in_byte), .flow_restart_i(flow_restart), .next_flow_o(next_flow),
    .tag_err_o(tag_err), .out_valid_o(out_valid), .out_flow_o(out_flow),
    .out_state_o(out_state), .out_match_o(out_match), .ld_en_i(ld_en),
    .ld_sel_i(ld_sel), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .load_ready_o(load_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;

  // reference model
  logic [SW-1:0] m_state [4];
  logic [RW-1:0] m_row   [NS];
  logic [BW-1:0] m_bid   [NS];
  logic          m_acc   [NS];
  logic [63:0]   m_bmp   [NB];
  logic [SW-1:0] m_trans [NT];

  logic          ring_v    [4];
  logic [1:0]    ring_flow [4];
  logic [SW-1:0] ring_next [4];
  logic          ring_acc  [4];
  string         ring_tag  [4];
  int            k;
  logic [1:0]    m_slot;
  logic          err_exp;
  logic [3:0]    p_rst;

  logic          ld_req;
  logic [1:0]    ld_req_sel;
  logic [AW-1:0] ld_req_addr;
  logic [DW-1:0] ld_req_data;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] model_next(input logic [SW-1:0] s, input logic [7:0] c);
    logic [63:0] bm;
    int cnt;
    int blk;
    bm  = m_bmp[m_bid[s]];
    blk = int'(c[7:2]);
    cnt = 0;
    for (int i = 0; i <= blk; i++) cnt += int'(bm[i]);
    return m_trans[(int'(m_row[s]) + ((cnt - 1 + 64) % 64)) % NT];
  endfunction

  // one cycle: check what the previous edges produced, then drive the next inputs
  task automatic step(input logic v, input logic [7:0] b, input logic bad,
                      input logic [3:0] rm, input string tag);
    int idx;
    logic [1:0] fl;
    logic [SW-1:0] nx;
    logic exp_rdy;
    idx = k % 4;
    chk("R2 rotation slot", 64'(next_flow), 64'(m_slot));
    if (ring_v[idx]) begin
      chk("R4 result valid", 64'(out_valid), 64'(1));
      chk("R4 result flow", 64'(out_flow), 64'(ring_flow[idx]));
      chk(ring_tag[idx], 64'(out_state), 64'(ring_next[idx]));
      chk("R5 accept flag", 64'(out_match), 64'(ring_acc[idx]));
      m_state[ring_flow[idx]] = ring_next[idx];
    end else begin
      chk("R10 no result", 64'(out_valid), 64'(0));
    end
    for (int f = 0; f < 4; f++) if (p_rst[f]) m_state[f] = '0;
    chk("R6 tag error flag", 64'(tag_err), 64'(err_exp));
    fl = bad ? m_slot + 2'd1 : m_slot;
    if (v && !bad) begin
      nx = model_next(m_state[fl], b);
      ring_v[idx]    = 1'b1;
      ring_flow[idx] = fl;
      ring_next[idx] = nx;
      ring_acc[idx]  = m_acc[nx];
      ring_tag[idx]  = tag;
    end else begin
      ring_v[idx] = 1'b0;
    end
    exp_rdy = !v && !ring_v[(k+1)%4] && !ring_v[(k+2)%4] && !ring_v[(k+3)%4];
    err_exp = v && bad;
    in_valid     = v;
    in_flow      = fl;
    in_byte      = b;
    flow_restart = rm;
    ld_en        = ld_req;
    ld_sel       = ld_req_sel;
    ld_addr      = ld_req_addr;
    ld_data      = ld_req_data;
    #1;
    chk("R8 load ready", 64'(load_ready), 64'(exp_rdy));
    if (ld_req && exp_rdy) begin
      case (ld_req_sel)
        2'd0: begin
          m_row[ld_req_addr[SW-1:0]] = ld_req_data[RW-1:0];
          m_bid[ld_req_addr[SW-1:0]] = ld_req_data[RW +: BW];
          m_acc[ld_req_addr[SW-1:0]] = ld_req_data[RW+BW];
        end
        2'd1: m_bmp[ld_req_addr[BW-1:0]] = ld_req_data;
        2'd2: m_trans[ld_req_addr[RW-1:0]] = ld_req_data[SW-1:0];
        default: ;
      endcase
    end
    ld_req = 1'b0;
    p_rst  = rm;
    k++;
    m_slot = m_slot + 2'd1;
    @(negedge clk);
  endtask

  task automatic load(input logic [1:0] sel, input int addr, input logic [63:0] data);
    ld_req      = 1'b1;
    ld_req_sel  = sel;
    ld_req_addr = AW'(addr);
    ld_req_data = data;
    step(1'b0, 8'h00, 1'b0, 4'h0, "R3");
  endtask

  function automatic logic [63:0] st_word(input int row, input int bid, input int acc);
    return 64'(row) | (64'(bid) << RW) | (64'(acc) << (RW + BW));
  endfunction

  initial begin
    int seed;
    logic [1:0] s;
    seed = $urandom(32'd20240511);
    rst_n = 1'b0; in_valid = 1'b0; in_flow = '0; in_byte = '0; flow_restart = '0;
    ld_en = 1'b0; ld_sel = '0; ld_addr = '0; ld_data = '0;
    ld_req = 1'b0; ld_req_sel = '0; ld_req_addr = '0; ld_req_data = '0;
    k = 0; m_slot = '0; err_exp = 1'b0; p_rst = '0;
    for (int f = 0; f < 4; f++) begin m_state[f] = '0; ring_v[f] = 1'b0; ring_tag[f] = "R3"; end
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 reset out_valid", 64'(out_valid), 64'(0));
    chk("R1 reset tag_err", 64'(tag_err), 64'(0));
    chk("R1 reset next_flow", 64'(next_flow), 64'(0));
    rst_n = 1'b1;
    chk("R1 next_flow after release", 64'(next_flow), 64'(0));

    // R9: fill the tables through the load port
    load(2'd1, 0, 64'h1);
    load(2'd1, 1, {64{1'b1}});
    for (int i = 2; i < NB; i++) load(2'd1, i, {$urandom, $urandom} | 64'h1);
    load(2'd0, 0, st_word(0, 1, 0));
    for (int i = 1; i < NS; i++)
      load(2'd0, i, st_word(int'($urandom % NT), int'($urandom % NB), int'($urandom % 2)));
    for (int i = 0; i < NT; i++) load(2'd2, i, 64'($urandom % NS));

    // R3: rank boundaries from state 0 (all-ones bitmap)
    step(1'b1, 8'h03, 1'b0, 4'h0, "R3 block 0");
    step(1'b1, 8'h04, 1'b0, 4'h0, "R3 block 1");
    step(1'b1, 8'hFF, 1'b0, 4'h0, "R3 block 63");
    step(1'b1, 8'h00, 1'b0, 4'h0, "R3 code 0");
    for (int i = 0; i < 8; i++) step(1'b1, (i % 2 == 0) ? 8'hFF : 8'h00, 1'b0, 4'h0, "R4 chained");

    // random traffic with wrong tags, restarts and blocked loads
    for (int i = 0; i < 600; i++) begin
      logic [3:0] rm;
      rm = ($urandom % 30 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
      if (i == 300) begin
        ld_req = 1'b1; ld_req_sel = 2'd2; ld_req_addr = '0; ld_req_data = 64'(m_trans[0] + 1'b1);
      end
      step(($urandom % 10) != 0, 8'($urandom), ($urandom % 20) == 0, rm, "R3 random");
    end

    // R7: restart on the same edge as that flow's write-back
    s = m_slot;
    step(1'b1, 8'h7C, 1'b0, 4'h0, "R3");
    step(1'b1, 8'h11, 1'b0, 4'h0, "R3");
    step(1'b1, 8'h22, 1'b0, 4'h0, "R3");
    step(1'b1, 8'h33, 1'b0, 4'(1 << s), "R3");
    step(1'b1, 8'hC8, 1'b0, 4'h0, "R7 restart wins");
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b0, 4'h0, "R3");

    // R9: reload while idle, including an ignored select code
    load(2'd3, 0, 64'h5);
    load(2'd2, NT - 1, 64'(NS - 1));
    load(2'd0, 2, st_word(NT - 1, 0, 1));
    load(2'd2, 1, 64'h2);
    for (int i = 0; i < 200; i++)
      step(($urandom % 8) != 0, 8'($urandom), 1'b0, 4'h0, "R9 after reload");
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b0, 4'h0, "R3");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule